// File: doc/BRIEF.md
# Serial Trace Capture Controller

This block sits between a debug probe's command layer and a serial trace receiver. The command layer turns trace mode on and off, sets the trace baud rate, arms a capture of N bytes, starts and stops the capture, and asks how many bytes have arrived so far. Bytes from the receiver go into a byte buffer through a write port whose address starts at zero and advances by one for each stored byte.

Turning the mode on claims two resources: the receiver and the transfer engine. Each one has an availability input. If either is busy, the mode stays off. Every other command is refused while the mode is off.

While a capture runs, a down-counter holds the number of bytes still to store. The count query reports the bytes already stored, computed as the armed count minus the remaining count. When the remaining count reaches zero, the transfer stops and raises a done flag.

Top module: `trace_capture_ctrl`

## Requirements
- R1: An enable command (op code 0, arg bit 0 = 1) while the mode is off and `rx_free` or `xfer_free` is low returns 0. The mode stays off, and neither claim output rises.
- R2: An enable command with both resources free returns 1 and raises `rx_claim`, `xfer_claim` and `pin_pull_up`. A disable command (op code 0, arg bit 0 = 0) returns 1 and drops both claims, the pull-up (pin left floating) and `rx_run`.
- R3: While the mode is off, the baud (1), control (2), capture (3) and count (4) commands return 0. They leave `rx_run`, `baud_rate` and the write port untouched.
- R4: After reset `baud_rate` is 115200. With the mode on, a baud command with arg between 1 and 10,000,000 inclusive applies arg and returns it. Any other value returns 0 and leaves the rate unchanged.
- R5: A capture command with the mode on returns 1 and arms arg (low CNT_W bits) bytes. Stored bytes go out on the write port one cycle after they arrive, in arrival order, at addresses 0, 1, 2, ...
- R6: A control command (op code 2) with the mode on returns 1. Arg bit 0 = 1 raises `rx_run`. Arg bit 0 = 0 drops `rx_run` and clears the armed count to 0.
- R7: The count command returns bytes stored since the last capture command (armed minus remaining). It returns 0 when the mode is off or the armed count is 0.
- R8: Once the remaining count is 0, or while `rx_run` is low, incoming bytes produce no write.
- R9: `done` rises when the last armed byte is stored while running. It clears on the next capture command.
- R10: Each command produces exactly one `rsp_valid` pulse, in the cycle after it is issued. Unknown op codes return 0.
- R11: A count query in the same cycle as an incoming byte reports the count before that byte. A byte arriving in the same cycle as a stop or a capture command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 32 | Command argument |
| rx_free | input | 1 | Receiver resource available |
| xfer_free | input | 1 | Transfer resource available |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Response value |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | 8 | Buffer write byte |
| done | output | 1 | Armed length reached |
| rx_claim | output | 1 | Receiver resource held |
| xfer_claim | output | 1 | Transfer resource held |
| rx_run | output | 1 | Receiver running |
| baud_rate | output | 32 | Configured trace baud rate |
| baud_load | output | 1 | Pulse: reprogram receiver |
| pin_pull_up | output | 1 | Trace pin pull-up enable |

## Verification
A byte can arrive in the same cycle as a count query, a stop command or a capture command. The bench drives each of these pairs in a single cycle. For a count query it expects the value from before the byte, and it expects that byte to be stored. For a stop or a capture command it expects no write for that byte, and a later count query confirms that the byte was not counted.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [2:0] {
        OP_MODE  = 3'd0,
        OP_BAUD  = 3'd1,
        OP_CTRL  = 3'd2,
        OP_CAPT  = 3'd3,
        OP_COUNT = 3'd4
    } tc_op_e;

    localparam logic [31:0] BAUD_RESET = 32'd115200;
    localparam logic [31:0] BAUD_LIMIT = 32'd10_000_000;

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } tc_rsp_t;

    function automatic logic baud_in_range(input logic [31:0] b);
        return (b != 32'd0) && (b <= BAUD_LIMIT);
    endfunction

endpackage

// File: rtl/tc_cmd_ctrl.sv
module tc_cmd_ctrl
    import tc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  tc_op_e           cmd_op,
    input  logic [31:0]      cmd_arg,
    input  logic             rx_free,
    input  logic             xfer_free,
    input  logic [31:0]      rcvd_cnt,
    output logic             mode_en,
    output logic             active,
    output logic [31:0]      baud_q,
    output logic             baud_load,
    output logic             cap_load,
    output logic [CNT_W-1:0] cap_num,
    output logic             cap_clear,
    output tc_rsp_t          rsp
);

    logic is_mode, is_baud, is_ctrl, is_capt;
    logic claim_ok, baud_ok;
    tc_rsp_t rsp_d;

    always_comb begin
        is_mode  = cmd_valid && (cmd_op == OP_MODE);
        is_baud  = cmd_valid && (cmd_op == OP_BAUD);
        is_ctrl  = cmd_valid && (cmd_op == OP_CTRL);
        is_capt  = cmd_valid && (cmd_op == OP_CAPT);
        claim_ok = rx_free && xfer_free;
        baud_ok  = baud_in_range(cmd_arg);

        cap_load  = is_capt && mode_en;
        cap_num   = cmd_arg[CNT_W-1:0];
        cap_clear = (is_ctrl && mode_en && !cmd_arg[0]) || (is_mode && !cmd_arg[0]);

        rsp_d.valid = cmd_valid;
        rsp_d.data  = 32'd0;
        case (cmd_op)
            OP_MODE:  rsp_d.data = cmd_arg[0] ? {31'd0, mode_en || claim_ok} : 32'd1;
            OP_BAUD:  rsp_d.data = (mode_en && baud_ok) ? cmd_arg : 32'd0;
            OP_CTRL:  rsp_d.data = {31'd0, mode_en};
            OP_CAPT:  rsp_d.data = {31'd0, mode_en};
            OP_COUNT: rsp_d.data = mode_en ? rcvd_cnt : 32'd0;
            default:  rsp_d.data = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_en   <= 1'b0;
            active    <= 1'b0;
            baud_q    <= BAUD_RESET;
            baud_load <= 1'b0;
            rsp       <= '0;
        end else begin
            rsp       <= rsp_d;
            baud_load <= is_baud && mode_en && baud_ok;
            if (is_baud && mode_en && baud_ok)
                baud_q <= cmd_arg;
            if (is_mode) begin
                if (cmd_arg[0]) begin
                    mode_en <= mode_en || claim_ok;
                end else begin
                    mode_en <= 1'b0;
                    active  <= 1'b0;
                end
            end else if (is_ctrl && mode_en) begin
                active <= cmd_arg[0];
            end
        end
    end

    // R3: commands other than mode are refused while the mode is off
    assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !mode_en && cmd_op != OP_MODE) |=> (rsp.valid && rsp.data == 32'd0));

    // R1: a failed enable keeps the mode off and answers 0
    assert_enable_fail_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_MODE && cmd_arg[0] && !mode_en && !(rx_free && xfer_free))
        |=> (!mode_en && rsp.data == 32'd0));

    // R10: a response only follows a command
    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
        rsp.valid |-> $past(cmd_valid));

    // R6: the receiver never runs without the mode
    assert_run_needs_mode_R6: assert property (@(posedge clk) disable iff (rst)
        active |-> mode_en);

endmodule

// File: rtl/tc_xfer.sv
module tc_xfer #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              cap_load,
    input  logic [CNT_W-1:0]  cap_num,
    input  logic              cap_clear,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic [31:0]       rcvd_cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0]  req_q, rem_q, ptr_q;
    logic [ADDR_W-1:0] ptr_addr;
    logic              take;

    generate
        if (ADDR_W <= CNT_W) begin : g_addr_trunc
            assign ptr_addr = ptr_q[ADDR_W-1:0];
        end else begin : g_addr_pad
            assign ptr_addr = {{(ADDR_W-CNT_W){1'b0}}, ptr_q};
        end
    endgenerate

    assign take     = active && in_valid && (rem_q != '0) && !cap_load && !cap_clear;
    assign rcvd_cnt = (req_q != '0) ? 32'(req_q - rem_q) : 32'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            rem_q   <= '0;
            ptr_q   <= '0;
            done    <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= take;
            if (cap_load) begin
                req_q <= cap_num;
                rem_q <= cap_num;
                ptr_q <= '0;
                done  <= 1'b0;
            end else if (cap_clear) begin
                req_q <= '0;
                rem_q <= '0;
                ptr_q <= '0;
            end else if (take) begin
                wr_addr <= ptr_addr;
                wr_data <= in_data;
                ptr_q   <= ptr_q + ONE;
                rem_q   <= rem_q - ONE;
                if (rem_q == ONE)
                    done <= 1'b1;
            end
        end
    end

    // R5: stored plus remaining always equals the armed count
    assert_balance_R5: assert property (@(posedge clk) disable iff (rst)
        (ptr_q + rem_q) == req_q);

    // R8: no write once nothing was left to store
    assert_stop_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(rem_q) != '0));

    // R9: done rises only with the counter exhausted
    assert_done_empty_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (rem_q == '0));

    // R11: a byte colliding with a stop or a capture command is not written
    assert_collision_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (cap_load || cap_clear) |=> !wr_en);

endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
    import tc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [31:0]       cmd_arg,
    input  logic              rx_free,
    input  logic              xfer_free,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              rx_claim,
    output logic              xfer_claim,
    output logic              rx_run,
    output logic [31:0]       baud_rate,
    output logic              baud_load,
    output logic              pin_pull_up
);

    logic             mode_en, active, cap_load, cap_clear;
    logic [CNT_W-1:0] cap_num;
    logic [31:0]      rcvd_cnt;
    tc_rsp_t          rsp;

    tc_cmd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (tc_op_e'(cmd_op)),
        .cmd_arg   (cmd_arg),
        .rx_free   (rx_free),
        .xfer_free (xfer_free),
        .rcvd_cnt  (rcvd_cnt),
        .mode_en   (mode_en),
        .active    (active),
        .baud_q    (baud_rate),
        .baud_load (baud_load),
        .cap_load  (cap_load),
        .cap_num   (cap_num),
        .cap_clear (cap_clear),
        .rsp       (rsp)
    );

    tc_xfer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .cap_load  (cap_load),
        .cap_num   (cap_num),
        .cap_clear (cap_clear),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .done      (done),
        .rcvd_cnt  (rcvd_cnt)
    );

    assign rsp_valid   = rsp.valid;
    assign rsp_data    = rsp.data;
    assign rx_claim    = mode_en;
    assign xfer_claim  = mode_en;
    assign rx_run      = active;
    assign pin_pull_up = mode_en;

    // R8: writes only happen while the receiver runs (one cycle earlier)
    assert_write_while_run_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(rx_run));

endmodule

// File: tb/trace_capture_ctrl_tb.sv
module trace_capture_ctrl_tb;

    localparam int ADDR_W = 12;
    localparam logic [2:0] C_MODE = 3'd0, C_BAUD = 3'd1, C_CTRL = 3'd2,
                           C_CAPT = 3'd3, C_COUNT = 3'd4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [31:0] cmd_arg = '0;
    logic rx_free = 1'b1, xfer_free = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic rsp_valid, wr_en, done, rx_claim, xfer_claim, rx_run, baud_load, pin_pull_up;
    logic [31:0] rsp_data, baud_rate;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] exp_rsp_q[$];
    string       rsp_tag_q[$];
    logic [19:0] exp_wr_q[$];
    string       wr_tag_q[$];

    always #4 clk = ~clk;

    trace_capture_ctrl #(.CNT_W(16), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .rx_free(rx_free), .xfer_free(xfer_free), .in_valid(in_valid), .in_data(in_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .rx_claim(rx_claim), .xfer_claim(xfer_claim),
        .rx_run(rx_run), .baud_rate(baud_rate), .baud_load(baud_load),
        .pin_pull_up(pin_pull_up)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compare responses and writes against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_rsp_q.size() == 0) chk(rsp_data, 32'hDEAD_BEEF, "R10 unexpected response");
                else chk(rsp_data, exp_rsp_q.pop_front(), rsp_tag_q.pop_front());
            end
            if (wr_en) begin
                if (exp_wr_q.size() == 0) chk({12'd0, wr_addr, wr_data}, 32'hDEAD_BEEF, "R8 unexpected write");
                else chk({12'd0, wr_addr, wr_data}, {12'd0, exp_wr_q.pop_front()}, wr_tag_q.pop_front());
            end
        end
    end

    task automatic issue(input logic [2:0] op, input logic [31:0] arg, input bit bv,
                         input logic [7:0] b, input bit wexp, input logic [ADDR_W-1:0] wa,
                         input logic [31:0] exp, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        in_valid = bv; in_data = b;
        exp_rsp_q.push_back(exp); rsp_tag_q.push_back(tag);
        if (bv && wexp) begin exp_wr_q.push_back({wa, b}); wr_tag_q.push_back(tag); end
        @(negedge clk);
        cmd_valid = 1'b0; in_valid = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [31:0] arg, input logic [31:0] exp,
                       input string tag);
        issue(op, arg, 1'b0, 8'h00, 1'b0, '0, exp, tag);
    endtask

    task automatic send(input logic [7:0] b, input bit wexp, input logic [ADDR_W-1:0] wa,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        if (wexp) begin exp_wr_q.push_back({wa, b}); wr_tag_q.push_back(tag); end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        chk({31'd0, rsp_valid}, 0, "R10 reset rsp_valid");
        chk({31'd0, wr_en}, 0, "R5 reset wr_en");
        chk({31'd0, done}, 0, "R9 reset done");
        chk({29'd0, rx_claim, xfer_claim, pin_pull_up}, 0, "R2 reset claims");
        chk(baud_rate, 32'd115200, "R4 reset baud");

        // R3: everything refused while mode is off
        cmd(C_BAUD, 32'd9600, 0, "R3 baud off");
        cmd(C_CTRL, 32'd1, 0, "R3 ctrl off");
        cmd(C_CAPT, 32'd5, 0, "R3 capt off");
        cmd(C_COUNT, 32'd0, 0, "R3 count off");
        send(8'h99, 1'b0, '0, "R3 byte off");
        chk({31'd0, rx_run}, 0, "R3 rx_run unchanged");
        chk(baud_rate, 32'd115200, "R3 baud unchanged");

        // R1: enable fails on either busy resource
        rx_free = 1'b0;
        cmd(C_MODE, 32'd1, 0, "R1 rx busy");
        chk({30'd0, rx_claim, pin_pull_up}, 0, "R1 no claim rx busy");
        rx_free = 1'b1; xfer_free = 1'b0;
        cmd(C_MODE, 32'd1, 0, "R1 xfer busy");
        chk({31'd0, xfer_claim}, 0, "R1 no claim xfer busy");
        xfer_free = 1'b1;

        // R2: enable
        cmd(C_MODE, 32'd1, 1, "R2 enable");
        chk({29'd0, rx_claim, xfer_claim, pin_pull_up}, 32'd7, "R2 claims held");

        // R10: unknown op
        cmd(3'd7, 32'd1, 0, "R10 unknown op");

        // R4: baud rate
        cmd(C_BAUD, 32'd1_000_000, 32'd1_000_000, "R4 baud 1M");
        chk(baud_rate, 32'd1_000_000, "R4 baud applied");
        cmd(C_BAUD, 32'd10_000_000, 32'd10_000_000, "R4 baud max");
        cmd(C_BAUD, 32'd10_000_001, 0, "R4 baud over max");
        cmd(C_BAUD, 32'd0, 0, "R4 baud zero");
        chk(baud_rate, 32'd10_000_000, "R4 baud kept");

        // R5 R6 R8 R9: capture of 4 bytes
        cmd(C_CAPT, 32'd4, 1, "R5 arm 4");
        send(8'h10, 1'b0, '0, "R8 byte before run");
        cmd(C_CTRL, 32'd1, 1, "R6 start");
        chk({31'd0, rx_run}, 1, "R6 rx_run high");
        send(8'h11, 1'b1, 12'd0, "R5 byte0");
        send(8'h22, 1'b1, 12'd1, "R5 byte1");
        chk({31'd0, done}, 0, "R9 not done yet");
        send(8'h33, 1'b1, 12'd2, "R5 byte2");
        send(8'h44, 1'b1, 12'd3, "R5 byte3");
        chk({31'd0, done}, 1, "R9 done");
        send(8'h55, 1'b0, '0, "R8 extra byte dropped");
        cmd(C_COUNT, 32'd0, 4, "R7 count full");

        // R11: count query collides with a byte
        cmd(C_CAPT, 32'd3, 1, "R5 arm 3");
        chk({31'd0, done}, 0, "R9 done cleared");
        send(8'h61, 1'b1, 12'd0, "R5 rearm byte0");
        issue(C_COUNT, 32'd0, 1'b1, 8'h62, 1'b1, 12'd1, 1, "R11 count with byte");
        cmd(C_COUNT, 32'd0, 2, "R7 count after");
        // R11: stop collides with a byte
        issue(C_CTRL, 32'd0, 1'b1, 8'h63, 1'b0, '0, 1, "R11 stop with byte");
        chk({31'd0, rx_run}, 0, "R6 rx_run low");
        cmd(C_COUNT, 32'd0, 0, "R6 count cleared");
        send(8'h64, 1'b0, '0, "R8 byte while stopped");
        // R11: capture command collides with a byte
        cmd(C_CTRL, 32'd1, 1, "R6 restart");
        issue(C_CAPT, 32'd2, 1'b1, 8'h70, 1'b0, '0, 1, "R11 arm with byte");
        send(8'h71, 1'b1, 12'd0, "R5 after collision");
        cmd(C_COUNT, 32'd0, 1, "R11 count after arm");

        // R2: disable
        cmd(C_MODE, 32'd0, 1, "R2 disable");
        chk({28'd0, rx_claim, xfer_claim, pin_pull_up, rx_run}, 0, "R2 released");
        cmd(C_COUNT, 32'd0, 0, "R7 count mode off");
        cmd(C_CAPT, 32'd2, 0, "R3 capt after disable");

        repeat (3) @(negedge clk);
        chk(exp_rsp_q.size(), 0, "R10 responses outstanding");
        chk(exp_wr_q.size(), 0, "R5 writes outstanding");
        summary();
    end

endmodule